// File: doc/BRIEF.md
# Bank-Group-Aware DRAM Column Scheduler

This block sits in a DRAM channel controller. It keeps the timing state of a channel whose banks are split into equal bank groups. In each cycle it picks at most one command from the pending per-bank requests. Every bank presents one request at a time: a valid flag, a row address and a direction. When the bank's open row matches the request, the block issues a read or a write to it. When the open row differs, the block precharges the bank once every restore timer of that bank and of its group has run out. Opening a row is a separate strobe from outside. The block accepts the strobe only for an idle bank whose precharge time has elapsed.

The block holds three channel-wide spacings: column-to-column, write-to-read and read-to-write. Each bank group has its own longer column-to-column spacing and a read-to-precharge spacing. The read-to-precharge spacing blocks precharge of every bank in the group. Each bank has its own activate-to-read, activate-to-write, activate-to-precharge, read-to-precharge, write-to-precharge and precharge-to-activate timers. The bank scan is round-robin and starts from a rotating pointer. The first eligible bank wins, and the requester sees an acknowledge pulse in the cycle its read or write goes out.

Top module: `dram_bg_sched`

## Requirements
- R1: After reset every bank is idle, all timers are zero and the scan pointer is zero. No command is issued to a bank that has not been opened, whatever requests are pending.
- R2: A read issues in the same cycle when the bank's request is valid, is a read, its row equals the open row and the bank is open. It also needs at least T_RCD cycles since the activate strobe that opened the row. `cmd_kind` is 1 for a read, and `req_ack` pulses only on that bank's bit.
- R3: A write follows the same rule with `cmd_kind` equal to 2, but it waits T_RCDWR cycles after the activate instead of T_RCD.
- R4: Two column commands in different bank groups are at least T_CCD cycles apart.
- R5: Two column commands in the same bank group are at least T_CCDL cycles apart. The group of bank b is b shifted right by log2(NBANK/NGRP).
- R6: A read waits at least T_WTR cycles after any write, and a write waits at least T_RTW cycles after any read.
- R7: The bank is precharged (`cmd_kind` 3, no acknowledge) when it is open and its request row differs from the open row. This requires T_RAS cycles since the activate, BL/2 cycles since the bank's last read and T_WTP cycles since its last write. The bank then becomes idle.
- R8: After a read, no bank of the same group may be precharged for T_RTPL cycles.
- R9: At most one command issues per cycle. Banks are examined in the order (i + pointer) mod NBANK, and the first eligible one wins. The pointer steps by one after each cycle that issued a command.
- R10: An activate strobe has no effect if the bank is open, or if fewer than T_RP cycles have passed since its precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NBANK | Per-bank request pending |
| req_write | input | NBANK | Per-bank direction, 1 = write |
| req_row | input | NBANK*ROW_W | Per-bank request row, bank b in bits [b*ROW_W +: ROW_W] |
| act_en | input | 1 | Activate strobe |
| act_bank | input | log2(NBANK) | Bank to open |
| act_row | input | ROW_W | Row to open |
| cmd_kind | output | 2 | 0 none, 1 read, 2 write, 3 precharge |
| cmd_bank | output | log2(NBANK) | Bank of the issued command |
| req_ack | output | NBANK | One-hot acknowledge of an issued read or write |

## Verification
The bench uses 8 banks in 2 groups and gives every timing a distinct small value: T_CCD 2, T_RTW 3, T_CCDL 4, T_WTR 5, T_RTPL 6. This makes every measured gap point to exactly one rule. A pair of banks in the same group and a pair across groups separate the per-group spacing from the channel spacing. Random request rows are drawn from four values, so row hits, row misses with precharge, and rotation among up to eight contending banks all occur often.

// File: rtl/dram_bg_sched_pkg.sv
package dram_bg_sched_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2,
        CMD_PRE  = 2'd3
    } cmd_e;

endpackage

// File: rtl/dram_bg_bank.sv
module dram_bg_bank #(
    parameter int ROW_W   = 4,
    parameter int CW      = 4,
    parameter int T_RCD   = 3,
    parameter int T_RCDWR = 2,
    parameter int T_RAS   = 5,
    parameter int T_RTP   = 4,
    parameter int T_WTP   = 6,
    parameter int T_RP    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic [ROW_W-1:0] open_row_in,
    input  logic             do_rd,
    input  logic             do_wr,
    input  logic             do_pre,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             rd_rdy,
    output logic             wr_rdy,
    output logic             pre_rdy
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CW-1:0]    rcd;
        logic [CW-1:0]    rcdwr;
        logic [CW-1:0]    ras;
        logic [CW-1:0]    rtp;
        logic [CW-1:0]    wtp;
        logic [CW-1:0]    rp;
    } bank_st_t;

    bank_st_t st_d, st_q;

    function automatic logic [CW-1:0] dec0(input logic [CW-1:0] v);
        return (v == '0) ? v : v - 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (open_en && !st_q.open && st_q.rp == '0) begin
            st_d.open  = 1'b1;
            st_d.row   = open_row_in;
            st_d.rcd   = CW'(T_RCD);
            st_d.rcdwr = CW'(T_RCDWR);
            st_d.ras   = CW'(T_RAS);
        end
        if (do_rd)  st_d.rtp = CW'(T_RTP);
        if (do_wr)  st_d.wtp = CW'(T_WTP);
        if (do_pre) begin
            st_d.open = 1'b0;
            st_d.rp   = CW'(T_RP);
        end
        st_d.rcd   = dec0(st_d.rcd);
        st_d.rcdwr = dec0(st_d.rcdwr);
        st_d.ras   = dec0(st_d.ras);
        st_d.rtp   = dec0(st_d.rtp);
        st_d.wtp   = dec0(st_d.wtp);
        st_d.rp    = dec0(st_d.rp);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign is_open  = st_q.open;
    assign open_row = st_q.row;
    assign rd_rdy   = st_q.open && st_q.rcd == '0;
    assign wr_rdy   = st_q.open && st_q.rcdwr == '0;
    assign pre_rdy  = st_q.open && st_q.ras == '0 && st_q.rtp == '0 && st_q.wtp == '0;

endmodule

// File: rtl/dram_bg_group.sv
module dram_bg_group #(
    parameter int CW     = 4,
    parameter int T_CCDL = 4,
    parameter int T_RTPL = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_rd,
    input  logic do_wr,
    output logic col_clr,
    output logic pre_clr
);

    typedef struct packed {
        logic [CW-1:0] ccdl;
        logic [CW-1:0] rtpl;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (do_rd || do_wr) st_d.ccdl = CW'(T_CCDL);
        if (do_rd)          st_d.rtpl = CW'(T_RTPL);
        if (st_d.ccdl != '0) st_d.ccdl = st_d.ccdl - 1'b1;
        if (st_d.rtpl != '0) st_d.rtpl = st_d.rtpl - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col_clr = st_q.ccdl == '0;
    assign pre_clr = st_q.rtpl == '0;

endmodule

// File: rtl/dram_bg_sched.sv
module dram_bg_sched
    import dram_bg_sched_pkg::*;
#(
    parameter int NBANK   = 8,
    parameter int NGRP    = 2,
    parameter int ROW_W   = 4,
    parameter int BL      = 8,
    parameter int T_CCD   = 2,
    parameter int T_CCDL  = 4,
    parameter int T_RTW   = 3,
    parameter int T_WTR   = 5,
    parameter int T_RTPL  = 6,
    parameter int T_WTP   = 6,
    parameter int T_RCD   = 3,
    parameter int T_RCDWR = 2,
    parameter int T_RAS   = 5,
    parameter int T_RP    = 3,
    localparam int BW     = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NBANK-1:0]       req_valid,
    input  logic [NBANK-1:0]       req_write,
    input  logic [NBANK*ROW_W-1:0] req_row,
    input  logic                   act_en,
    input  logic [BW-1:0]          act_bank,
    input  logic [ROW_W-1:0]       act_row,
    output logic [1:0]             cmd_kind,
    output logic [BW-1:0]          cmd_bank,
    output logic [NBANK-1:0]       req_ack
);

    localparam int BPG      = NBANK / NGRP;
    localparam int BG_SHIFT = $clog2(BPG);
    localparam int T_RTP    = BL / 2;
    localparam int TMAX1    = (T_CCD > T_CCDL) ? T_CCD : T_CCDL;
    localparam int TMAX2    = (T_RTW > T_WTR) ? T_RTW : T_WTR;
    localparam int TMAX3    = (T_RTPL > T_WTP) ? T_RTPL : T_WTP;
    localparam int TMAX4    = (T_RCD > T_RAS) ? T_RCD : T_RAS;
    localparam int TMAX5    = (T_RP > T_RTP) ? T_RP : T_RTP;
    localparam int TMAXA    = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
    localparam int TMAXB    = (TMAX3 > TMAX4) ? TMAX3 : TMAX4;
    localparam int TMAXC    = (TMAX5 > T_RCDWR) ? TMAX5 : T_RCDWR;
    localparam int TMAXAB   = (TMAXA > TMAXB) ? TMAXA : TMAXB;
    localparam int TMAX     = (TMAXAB > TMAXC) ? TMAXAB : TMAXC;
    localparam int CW       = $clog2(TMAX + 1);

    typedef struct packed {
        logic [CW-1:0] ccd;
        logic [CW-1:0] wtr;
        logic [CW-1:0] rtw;
        logic [BW-1:0] prio;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic [NBANK-1:0] b_open, b_rd_rdy, b_wr_rdy, b_pre_rdy, b_hit;
    logic [NBANK-1:0] rd_ok, wr_ok, pre_ok;
    logic [NBANK-1:0] b_open_en, b_do_rd, b_do_wr, b_do_pre;
    logic [NGRP-1:0]  g_col_clr, g_pre_clr, g_do_rd, g_do_wr;
    logic [ROW_W-1:0] b_row [NBANK];

    cmd_e          pick_kind;
    logic [BW-1:0] pick_bank;
    logic [BW-1:0] pick_grp;

    // per-bank timing state and eligibility
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int GI = b / BPG;

        assign b_open_en[b] = act_en && (act_bank == BW'(b));

        dram_bg_bank #(
            .ROW_W(ROW_W), .CW(CW), .T_RCD(T_RCD), .T_RCDWR(T_RCDWR),
            .T_RAS(T_RAS), .T_RTP(T_RTP), .T_WTP(T_WTP), .T_RP(T_RP)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .open_en    (b_open_en[b]),
            .open_row_in(act_row),
            .do_rd      (b_do_rd[b]),
            .do_wr      (b_do_wr[b]),
            .do_pre     (b_do_pre[b]),
            .is_open    (b_open[b]),
            .open_row   (b_row[b]),
            .rd_rdy     (b_rd_rdy[b]),
            .wr_rdy     (b_wr_rdy[b]),
            .pre_rdy    (b_pre_rdy[b])
        );

        assign b_hit[b]  = b_row[b] == req_row[b*ROW_W +: ROW_W];
        assign rd_ok[b]  = req_valid[b] && !req_write[b] && b_rd_rdy[b] && b_hit[b]
                           && g_col_clr[GI];
        assign wr_ok[b]  = req_valid[b] && req_write[b] && b_wr_rdy[b] && b_hit[b]
                           && g_col_clr[GI];
        assign pre_ok[b] = req_valid[b] && b_open[b] && !b_hit[b] && b_pre_rdy[b]
                           && g_pre_clr[GI];
    end

    // per-group spacing state
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign g_do_rd[g] = (pick_kind == CMD_RD) && (pick_grp == BW'(g));
        assign g_do_wr[g] = (pick_kind == CMD_WR) && (pick_grp == BW'(g));

        dram_bg_group #(
            .CW(CW), .T_CCDL(T_CCDL), .T_RTPL(T_RTPL)
        ) u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .do_rd  (g_do_rd[g]),
            .do_wr  (g_do_wr[g]),
            .col_clr(g_col_clr[g]),
            .pre_clr(g_pre_clr[g])
        );
    end

    // rotating scan: first eligible bank from the pointer wins
    always_comb begin
        int  j;
        logic rd_gate, wr_gate;
        rd_gate   = (st_q.ccd == '0) && (st_q.wtr == '0);
        wr_gate   = (st_q.ccd == '0) && (st_q.rtw == '0);
        pick_kind = CMD_NONE;
        pick_bank = '0;
        for (int i = 0; i < NBANK; i++) begin
            j = (i + int'(st_q.prio)) % NBANK;
            if (pick_kind == CMD_NONE) begin
                if (rd_ok[j] && rd_gate) begin
                    pick_kind = CMD_RD;
                    pick_bank = BW'(j);
                end else if (wr_ok[j] && wr_gate) begin
                    pick_kind = CMD_WR;
                    pick_bank = BW'(j);
                end else if (pre_ok[j]) begin
                    pick_kind = CMD_PRE;
                    pick_bank = BW'(j);
                end
            end
        end
    end

    assign pick_grp = pick_bank >> BG_SHIFT;
    assign b_do_rd  = (pick_kind == CMD_RD)  ? (NBANK'(1) << pick_bank) : '0;
    assign b_do_wr  = (pick_kind == CMD_WR)  ? (NBANK'(1) << pick_bank) : '0;
    assign b_do_pre = (pick_kind == CMD_PRE) ? (NBANK'(1) << pick_bank) : '0;

    // channel-wide spacing and pointer
    always_comb begin
        st_d = st_q;
        if (pick_kind == CMD_RD) begin
            st_d.ccd = CW'(T_CCD);
            st_d.rtw = CW'(T_RTW);
        end
        if (pick_kind == CMD_WR) begin
            st_d.ccd = CW'(T_CCD);
            st_d.wtr = CW'(T_WTR);
        end
        if (st_d.ccd != '0) st_d.ccd = st_d.ccd - 1'b1;
        if (st_d.wtr != '0) st_d.wtr = st_d.wtr - 1'b1;
        if (st_d.rtw != '0) st_d.rtw = st_d.rtw - 1'b1;
        if (pick_kind != CMD_NONE) begin
            st_d.prio = (st_q.prio == BW'(NBANK - 1)) ? '0 : st_q.prio + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_kind = pick_kind;
    assign cmd_bank = pick_bank;
    assign req_ack  = b_do_rd | b_do_wr;

endmodule

// File: rtl/dram_bg_sched_chk.sv
module dram_bg_sched_chk
    import dram_bg_sched_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int NGRP   = 2,
    parameter int T_CCD  = 2,
    parameter int T_CCDL = 4,
    parameter int T_RTW  = 3,
    parameter int T_WTR  = 5,
    localparam int BW    = $clog2(NBANK)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cmd_kind,
    input logic [BW-1:0]    cmd_bank,
    input logic [NBANK-1:0] req_ack
);

    localparam int BG_SHIFT = $clog2(NBANK / NGRP);

    logic [15:0] since_col, since_rd, since_wr;
    logic        is_col, is_rd, is_wr;
    logic [BW-1:0] grp_of_cmd;

    assign is_rd      = cmd_kind == CMD_RD;
    assign is_wr      = cmd_kind == CMD_WR;
    assign is_col     = is_rd || is_wr;
    assign grp_of_cmd = cmd_bank >> BG_SHIFT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_col <= 16'hFFFF;
            since_rd  <= 16'hFFFF;
            since_wr  <= 16'hFFFF;
        end else begin
            since_col <= is_col ? 16'd1 : ((since_col == 16'hFFFF) ? since_col : since_col + 1'b1);
            since_rd  <= is_rd  ? 16'd1 : ((since_rd  == 16'hFFFF) ? since_rd  : since_rd  + 1'b1);
            since_wr  <= is_wr  ? 16'd1 : ((since_wr  == 16'hFFFF) ? since_wr  : since_wr  + 1'b1);
        end
    end

    a_r9_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ack));

    a_r2_ack_on_column: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ack != '0) |-> (is_col && req_ack[cmd_bank]));

    a_r7_pre_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_kind == CMD_PRE) |-> (req_ack == '0));

    a_r4_ccd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since_col >= 16'(T_CCD)));

    a_r6_wtr_gap: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |-> (since_wr >= 16'(T_WTR)));

    a_r6_rtw_gap: assert property (@(posedge clk) disable iff (!rst_n)
        is_wr |-> (since_rd >= 16'(T_RTW)));

    for (genvar g = 0; g < NGRP; g++) begin : g_grp_chk
        logic [15:0] since_g;
        always_ff @(posedge clk) begin
            if (!rst_n) since_g <= 16'hFFFF;
            else if (is_col && grp_of_cmd == BW'(g)) since_g <= 16'd1;
            else if (since_g != 16'hFFFF) since_g <= since_g + 1'b1;
        end

        a_r5_ccdl_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (is_col && grp_of_cmd == BW'(g)) |-> (since_g >= 16'(T_CCDL)));
    end

endmodule

bind dram_bg_sched dram_bg_sched_chk #(
    .NBANK(NBANK), .NGRP(NGRP), .T_CCD(T_CCD), .T_CCDL(T_CCDL),
    .T_RTW(T_RTW), .T_WTR(T_WTR)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank),
    .req_ack (req_ack)
);

// File: tb/dram_bg_sched_tb.sv
module dram_bg_sched_tb;

    localparam int NB = 8, NG = 2, RW = 4, BL = 8;
    localparam int T_CCD = 2, T_CCDL = 4, T_RTW = 3, T_WTR = 5, T_RTPL = 6;
    localparam int T_WTP = 6, T_RCD = 3, T_RCDWR = 2, T_RAS = 5, T_RP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] req_valid = '0;
    logic [NB-1:0] req_write = '0;
    logic [NB*RW-1:0] req_row = '0;
    logic          act_en = 1'b0;
    logic [2:0]    act_bank = '0;
    logic [RW-1:0] act_row = '0;
    logic [1:0]    cmd_kind;
    logic [2:0]    cmd_bank;
    logic [NB-1:0] req_ack;

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    // last sampled outputs
    logic [1:0]    s_kind;
    logic [2:0]    s_bank;
    logic [NB-1:0] s_ack = '0;
    int            s_cyc;

    // reference model state
    int ma[NB], mrow[NB], mrcd[NB], mrcdwr[NB], mras[NB], mrtp[NB], mwtp[NB], mrp[NB];
    int mccdl[NG], mrtpl[NG];
    int mccd, mwtr, mrtw, mprio;

    always #4 clk = ~clk;

    dram_bg_sched u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_row(req_row), .act_en(act_en), .act_bank(act_bank), .act_row(act_row),
        .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .req_ack(req_ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int dec0(input int v);
        return (v > 0) ? v - 1 : 0;
    endfunction

    function automatic int rrow(input int b);
        return int'(req_row[b*RW +: RW]);
    endfunction

    // sampler and model, just before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            s_kind = cmd_kind; s_bank = cmd_bank; s_ack = req_ack; s_cyc = cyc;
            if (!rst_n) begin
                for (int b = 0; b < NB; b++) begin
                    ma[b] = 0; mrow[b] = 0; mrcd[b] = 0; mrcdwr[b] = 0;
                    mras[b] = 0; mrtp[b] = 0; mwtp[b] = 0; mrp[b] = 0;
                end
                for (int g = 0; g < NG; g++) begin mccdl[g] = 0; mrtpl[g] = 0; end
                mccd = 0; mwtr = 0; mrtw = 0; mprio = 0;
            end else begin
                int ek, eb, g, j;
                bit hit;
                string tag;
                ek = 0; eb = 0;
                for (int i = 0; i < NB; i++) begin
                    j = (i + mprio) % NB;
                    g = j / (NB / NG);
                    hit = req_valid[j] && ma[j] == 1 && mrow[j] == rrow(j);
                    if (ek == 0) begin
                        if (hit && !req_write[j] && mrcd[j] == 0 && mccdl[g] == 0
                            && mccd == 0 && mwtr == 0) begin ek = 1; eb = j; end
                        else if (hit && req_write[j] && mrcdwr[j] == 0 && mccdl[g] == 0
                            && mccd == 0 && mrtw == 0) begin ek = 2; eb = j; end
                        else if (req_valid[j] && ma[j] == 1 && mrow[j] != rrow(j)
                            && mras[j] == 0 && mrtp[j] == 0 && mwtp[j] == 0
                            && mrtpl[g] == 0) begin ek = 3; eb = j; end
                    end
                end
                tag = (ek == 1) ? "R2 read pick" : (ek == 2) ? "R3 write pick" :
                      (ek == 3) ? "R7 precharge pick" : "R9 idle cycle";
                chk(int'(cmd_kind) == ek, tag, int'(cmd_kind), ek);
                if (ek != 0) chk(int'(cmd_bank) == eb, "R9 scan winner bank", int'(cmd_bank), eb);
                chk(req_ack == ((ek == 1 || ek == 2) ? NB'(1) << eb : NB'(0)),
                    "R2 acknowledge vector", int'(req_ack), (ek == 1 || ek == 2) ? (1 << eb) : 0);
                // model update
                if (act_en && ma[act_bank] == 0 && mrp[act_bank] == 0) begin
                    ma[act_bank] = 1; mrow[act_bank] = int'(act_row);
                    mrcd[act_bank] = T_RCD; mrcdwr[act_bank] = T_RCDWR; mras[act_bank] = T_RAS;
                end
                g = eb / (NB / NG);
                if (ek == 1) begin
                    mccd = T_CCD; mccdl[g] = T_CCDL; mrtw = T_RTW;
                    mrtp[eb] = BL / 2; mrtpl[g] = T_RTPL;
                end else if (ek == 2) begin
                    mccd = T_CCD; mccdl[g] = T_CCDL; mwtr = T_WTR; mwtp[eb] = T_WTP;
                end else if (ek == 3) begin
                    ma[eb] = 0; mrp[eb] = T_RP;
                end
                for (int b = 0; b < NB; b++) begin
                    mrcd[b] = dec0(mrcd[b]); mrcdwr[b] = dec0(mrcdwr[b]); mras[b] = dec0(mras[b]);
                    mrtp[b] = dec0(mrtp[b]); mwtp[b] = dec0(mwtp[b]); mrp[b] = dec0(mrp[b]);
                end
                for (int k = 0; k < NG; k++) begin mccdl[k] = dec0(mccdl[k]); mrtpl[k] = dec0(mrtpl[k]); end
                mccd = dec0(mccd); mwtr = dec0(mwtr); mrtw = dec0(mrtw);
                if (ek != 0) mprio = (mprio + 1) % NB;
            end
            cyc++;
        end
    end

    // advance to the next falling edge; drop acknowledged requests and the strobe
    task automatic step();
        @(negedge clk);
        req_valid = req_valid & ~s_ack;
        act_en = 1'b0;
    endtask

    task automatic quiet(input int n);
        @(negedge clk);
        req_valid = '0;
        act_en = 1'b0;
        repeat (n) step();
    endtask

    task automatic set_req(input int b, input bit wr, input int row);
        req_valid[b] = 1'b1;
        req_write[b] = wr;
        req_row[b*RW +: RW] = RW'(row);
    endtask

    task automatic do_act(input int b, input int row);
        act_en = 1'b1;
        act_bank = 3'(b);
        act_row = RW'(row);
    endtask

    // wait for a command of a given kind (bank -1 = any); returns at the next falling edge
    task automatic wait_cmd(input int kind, input int bank, output int c, output int got);
        c = -1; got = -1;
        for (int n = 0; n < 60; n++) begin
            step();
            if (int'(s_kind) == kind && (bank < 0 || int'(s_bank) == bank)) begin
                c = s_cyc; got = int'(s_bank);
                break;
            end
        end
    endtask

    initial begin
        int t1, t2, b1, b2, a, p;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(cmd_kind == 2'd0, "R1 output in reset", int'(cmd_kind), 0);
        rst_n = 1'b1;

        // R1: requests to banks that were never opened are not served
        for (int b = 0; b < NB; b++) set_req(b, b[0], b);
        for (int n = 0; n < 5; n++) begin
            step();
            chk(s_kind == 2'd0, "R1 no command after reset", int'(s_kind), 0);
        end
        quiet(4);

        // R2: read after activate waits tRCD
        a = cyc; do_act(0, 5); set_req(0, 0, 5);
        wait_cmd(1, 0, t1, b1);
        chk(t1 - a == T_RCD, "R2 activate-to-read", t1 - a, T_RCD);
        quiet(20);
        // R3: write after activate waits tRCDWR
        a = cyc; do_act(4, 2); set_req(4, 1, 2);
        wait_cmd(2, 4, t1, b1);
        chk(t1 - a == T_RCDWR, "R3 activate-to-write", t1 - a, T_RCDWR);
        quiet(20);
        do_act(1, 1); quiet(3);
        do_act(5, 1); quiet(20);

        // R4: reads in different groups
        set_req(0, 0, 5); set_req(4, 0, 2);
        wait_cmd(1, -1, t1, b1);
        wait_cmd(1, -1, t2, b2);
        chk(t2 - t1 == T_CCD, "R4 cross-group read gap", t2 - t1, T_CCD);
        chk(b1 != b2, "R4 both banks served", b2, 4 - b1);
        quiet(20);

        // R5: reads in the same group
        set_req(0, 0, 5); set_req(1, 0, 1);
        wait_cmd(1, -1, t1, b1);
        wait_cmd(1, -1, t2, b2);
        chk(t2 - t1 == T_CCDL, "R5 same-group read gap", t2 - t1, T_CCDL);
        quiet(20);

        // R6: write then read, read then write
        set_req(0, 1, 5);
        wait_cmd(2, 0, t1, b1);
        set_req(4, 0, 2);
        wait_cmd(1, 4, t2, b2);
        chk(t2 - t1 == T_WTR, "R6 write-to-read gap", t2 - t1, T_WTR);
        quiet(20);
        set_req(0, 0, 5);
        wait_cmd(1, 0, t1, b1);
        set_req(5, 1, 1);
        wait_cmd(2, 5, t2, b2);
        chk(t2 - t1 == T_RTW, "R6 read-to-write gap", t2 - t1, T_RTW);
        quiet(20);

        // R8: group read-to-precharge blocks a neighbour's precharge
        set_req(0, 0, 5);
        wait_cmd(1, 0, t1, b1);
        set_req(1, 0, 7);
        wait_cmd(3, 1, p, b2);
        chk(p - t1 == T_RTPL, "R8 read-to-precharge in group", p - t1, T_RTPL);
        // R10: activate inside tRP is ignored; R7 reopen after tRP
        do_act(1, 7);
        step(); step();
        do_act(1, 7);
        wait_cmd(1, 1, t2, b2);
        chk(t2 - p == T_RP + T_RCD, "R10 early activate ignored", t2 - p, T_RP + T_RCD);
        // R10: activate to an open bank keeps its row
        quiet(20);
        do_act(1, 3); step();
        set_req(1, 0, 7);
        wait_cmd(1, 1, t2, b2);
        chk(t2 >= 0, "R10 open bank keeps row", t2 >= 0, 1);
        quiet(20);

        // R9: random traffic checked against the model every cycle
        for (int n = 0; n < 4000; n++) begin
            step();
            for (int b = 0; b < NB; b++) begin
                if (!req_valid[b] && ($urandom % 4) == 0)
                    set_req(b, bit'($urandom % 2), int'($urandom % 4));
            end
            if (($urandom % 3) == 0) do_act(int'($urandom % NB), int'($urandom % 4));
        end
        quiet(10);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule